// File: doc/BRIEF.md
# Synthesizer Configuration Register

This block keeps the configuration word of a clock synthesizer: a 9-bit feedback divider value, a 2-bit post-divider select and a 3-bit test-mode select. Downstream divider logic reads the three fields straight from its outputs. The word can be written along two independent routes. In the serial route, a data bit is clocked into a 14-bit shift register by a slow serial clock, and a load strobe then copies the register across. In the parallel route, divider and select pins are copied across by a second strobe. The two strobes have opposite polarity.

All logic runs on a fast system clock. The serial clock and both strobes pass through two-flop synchronizers, and so does the serial data bit. An edge of the serial clock is found by comparing successive synchronized samples. A latch that is "transparent" is modelled by a register that reloads on every system cycle while its strobe sits at the open level. A small state machine decodes the two synchronized strobes into four states. CFG_HOLD means both strobes are closed. CFG_SER_OPEN means only the serial strobe is open. CFG_PAR_OPEN means only the parallel strobe is open. CFG_BOTH_OPEN means both are open. Every state can move to every other state in one cycle when the strobes change. The transitions are named for the strobe event that causes them: serial open, serial close, parallel open, parallel close, and their combinations.

Top module: `synth_cfg_reg`

## Requirements
- R1: Each rising edge of the serial clock shifts the serial data bit into bit 0 of a 14-bit shift register, and all older bits move one place toward bit 13. The bit position sets the field. Bits 13..11 form the test field, with the first shifted bit ending in bit 2 of that field. Bits 10..9 form the post-divider select. Bits 8..0 form the feedback divider, most significant bit first.
- R2: While the serial load strobe is high, the three outputs follow the shift register fields, within 6 system cycles of any change.
- R3: While the serial load strobe is low, shifting does not change the outputs. When the strobe falls, the outputs keep the word present just before the fall.
- R4: While the parallel load strobe is low, the divider and select outputs follow their parallel pins. When the strobe rises, they keep the pin values present just before the rise.
- R5: While the parallel load strobe is high, changes on the parallel pins have no effect on any output.
- R6: The parallel route never changes the test-mode output.
- R7: When both strobes are open together, the divider and select outputs come from the parallel pins and the test output comes from the shift register.
- R8: Reset sets all three outputs to all ones and clears the shift register. A serial load with no shifting after reset therefore gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial load strobe, open while high |
| par_load_i | input | 1 | Parallel load strobe, open while low |
| par_m_i | input | 9 | Parallel feedback divider value |
| par_n_i | input | 2 | Parallel post-divider select |
| cfg_m_o | output | 9 | Latched feedback divider value |
| cfg_n_o | output | 2 | Latched post-divider select |
| cfg_t_o | output | 3 | Latched test-mode select |

## Verification
A shift register that is off by one place, or that has its fields in the wrong order, shows up at the outputs as a rotated or swapped word on the first serial load after the shifting. A state machine that decodes one strobe with the wrong polarity lets the outputs move while they should hold, or freezes them while they should follow. That error is visible within a few system cycles of the strobe or pin change. A mistake in priority or field routing shows up only when both strobes are open together, or when a parallel load happens after a serial one, because the test field then comes from the wrong route.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int CFG_M_W = 9;
    localparam int CFG_N_W = 2;
    localparam int CFG_T_W = 3;

    typedef enum logic [1:0] {
        CFG_HOLD      = 2'b00,
        CFG_SER_OPEN  = 2'b01,
        CFG_PAR_OPEN  = 2'b10,
        CFG_BOTH_OPEN = 2'b11
    } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic safe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                safe_q <= RST_VAL[b];
            end else begin
                meta_q <= d_i[b];
                safe_q <= meta_q;
            end
        end
        assign q_o[b] = safe_q;
    end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    output logic [WORD_W-1:0] word_o
);
    logic sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            word_o    <= '0;
        end else begin
            sclk_prev <= sclk_s;
            if (sclk_s && !sclk_prev)
                word_o <= {word_o[WORD_W-2:0], sdata_s};
        end
    end
endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
    import synth_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sload_s,
    input  logic       pload_s,
    output cfg_state_e state_o,
    output logic       ser_upd_o,
    output logic       par_upd_o
);
    cfg_state_e state_q;
    cfg_state_e state_d;

    always_comb begin
        unique case ({!pload_s, sload_s})
            2'b00:   state_d = CFG_HOLD;
            2'b01:   state_d = CFG_SER_OPEN;
            2'b10:   state_d = CFG_PAR_OPEN;
            default: state_d = CFG_BOTH_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CFG_HOLD:      begin ser_upd_o = 1'b0; par_upd_o = 1'b0; end
            CFG_SER_OPEN:  begin ser_upd_o = 1'b1; par_upd_o = 1'b0; end
            CFG_PAR_OPEN:  begin ser_upd_o = 1'b0; par_upd_o = 1'b1; end
            CFG_BOTH_OPEN: begin ser_upd_o = 1'b1; par_upd_o = 1'b1; end
            default:       begin ser_upd_o = 1'b0; par_upd_o = 1'b0; end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
    import synth_cfg_pkg::*;
#(
    parameter int M_W = CFG_M_W,
    parameter int N_W = CFG_N_W,
    parameter int T_W = CFG_T_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk_i,
    input  logic           ser_data_i,
    input  logic           ser_load_i,
    input  logic           par_load_i,
    input  logic [M_W-1:0] par_m_i,
    input  logic [N_W-1:0] par_n_i,
    output logic [M_W-1:0] cfg_m_o,
    output logic [N_W-1:0] cfg_n_o,
    output logic [T_W-1:0] cfg_t_o
);
    localparam int WORD_W = M_W + N_W + T_W;
    localparam int N_LO   = M_W;
    localparam int T_LO   = M_W + N_W;

    // synced: {parallel strobe, serial strobe, serial data, serial clock}
    logic [3:0]        sync_q;
    logic              sclk_s, sdata_s, sload_s, pload_s;
    logic [WORD_W-1:0] shift_q;
    cfg_state_e        state;
    logic              ser_upd, par_upd;

    cfg_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({par_load_i, ser_load_i, ser_data_i, ser_clk_i}),
        .q_o  (sync_q)
    );
    assign {pload_s, sload_s, sdata_s, sclk_s} = sync_q;

    cfg_shift #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .sdata_s(sdata_s),
        .word_o (shift_q)
    );

    cfg_load_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sload_s  (sload_s),
        .pload_s  (pload_s),
        .state_o  (state),
        .ser_upd_o(ser_upd),
        .par_upd_o(par_upd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_m_o <= '1;
            cfg_n_o <= '1;
            cfg_t_o <= '1;
        end else begin
            if (par_upd) begin
                cfg_m_o <= par_m_i;
                cfg_n_o <= par_n_i;
            end else if (ser_upd) begin
                cfg_m_o <= shift_q[M_W-1:0];
                cfg_n_o <= shift_q[N_LO +: N_W];
            end
            if (ser_upd)
                cfg_t_o <= shift_q[T_LO +: T_W];
        end
    end
endmodule

// File: rtl/synth_cfg_reg_chk.sv
module synth_cfg_reg_chk #(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sclk_s,
    input logic                 sdata_s,
    input logic [M_W+N_W+T_W-1:0] shift_q,
    input logic                 ser_upd,
    input logic                 par_upd,
    input logic [M_W-1:0]       par_m_i,
    input logic [N_W-1:0]       par_n_i,
    input logic [M_W-1:0]       cfg_m_o,
    input logic [N_W-1:0]       cfg_n_o,
    input logic [T_W-1:0]       cfg_t_o
);
    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_s) |=> shift_q[0] == $past(sdata_s));

    p_ser_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_upd && !par_upd) |=> cfg_m_o == $past(shift_q[M_W-1:0]));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_upd && !par_upd) |=> ($stable(cfg_m_o) && $stable(cfg_n_o) && $stable(cfg_t_o)));

    p_par_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        par_upd |=> (cfg_m_o == $past(par_m_i) && cfg_n_o == $past(par_n_i)));

    p_t_serial_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_upd |=> $stable(cfg_t_o));
endmodule

bind synth_cfg_reg synth_cfg_reg_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (sclk_s),
    .sdata_s(sdata_s),
    .shift_q(shift_q),
    .ser_upd(ser_upd),
    .par_upd(par_upd),
    .par_m_i(par_m_i),
    .par_n_i(par_n_i),
    .cfg_m_o(cfg_m_o),
    .cfg_n_o(cfg_n_o),
    .cfg_t_o(cfg_t_o)
);

// File: tb/tb_synth_cfg_reg.sv
module tb_synth_cfg_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_load_i = 1'b0;
    logic       par_load_i = 1'b1;
    logic [8:0] par_m_i = '1;
    logic [1:0] par_n_i = '1;
    logic [8:0] cfg_m_o;
    logic [1:0] cfg_n_o;
    logic [2:0] cfg_t_o;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    synth_cfg_reg dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_load_i(ser_load_i),
        .par_load_i(par_load_i), .par_m_i(par_m_i), .par_n_i(par_n_i),
        .cfg_m_o(cfg_m_o), .cfg_n_o(cfg_n_o), .cfg_t_o(cfg_t_o)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [8:0] em,
                       input logic [1:0] en, input logic [2:0] et);
        checks++;
        if (cfg_m_o !== em || cfg_n_o !== en || cfg_t_o !== et) begin
            errors++;
            $display("FAIL %s: got m=%h n=%h t=%h, expected m=%h n=%h t=%h",
                     req, cfg_m_o, cfg_n_o, cfg_t_o, em, en, et);
        end
    endtask

    task automatic shift_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) begin
            ser_data_i = w[i];
            ser_clk_i  = 1'b0;
            idle(4);
            ser_clk_i  = 1'b1;
            idle(4);
        end
        ser_clk_i = 1'b0;
        idle(4);
    endtask

    task automatic pulse_sload();
        ser_load_i = 1'b1;
        idle(8);
        ser_load_i = 1'b0;
        idle(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [13:0] w, last;
        logic [8:0]  pm, hm;
        logic [1:0]  pn, hn;
        idle(3);
        chk("R8 in reset", 9'h1FF, 2'h3, 3'h7);
        rst_n = 1'b1;
        idle(8);
        chk("R8 after reset", 9'h1FF, 2'h3, 3'h7);
        pulse_sload();
        chk("R8 cleared shift register", 9'h000, 2'h0, 3'h0);

        // R1/R2 serial sweep
        last = '0;
        for (int i = 0; i < 34; i++) begin
            w = (i == 0) ? 14'h3FFF : (i == 1) ? 14'h0001 : 14'((i * 5821 + 97) & 16'h3FFF);
            shift_word(w);
            chk("R3 shift without load holds", last[8:0], last[10:9], last[13:11]);
            pulse_sload();
            chk("R1 R2 serial word fields", w[8:0], w[10:9], w[13:11]);
            last = w;
        end

        // R2 track while open, R3 hold value at fall
        ser_load_i = 1'b1;
        idle(8);
        shift_word(14'h2A5C);
        chk("R2 tracks while strobe high", 9'h05C, 2'h1, 3'h5);
        ser_load_i = 1'b0;
        idle(8);
        shift_word(14'h1234);
        chk("R3 holds after strobe fall", 9'h05C, 2'h1, 3'h5);
        last = 14'h2A5C;

        // R4/R5/R6 parallel sweep
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 8; k++) begin
                pm = 9'((k * 73 + n * 11 + (k == 7 ? 511 : 0)) % 512);
                pn = 2'(n);
                hm = ~pm;
                hn = ~pn;
                par_m_i = hm; par_n_i = hn;
                par_load_i = 1'b0;
                idle(8);
                chk("R4 tracks while strobe low", hm, hn, last[13:11]);
                par_m_i = pm; par_n_i = pn;
                idle(8);
                par_load_i = 1'b1;
                idle(8);
                par_m_i = hm; par_n_i = hn;
                idle(8);
                chk("R5 R6 captured at rise, pins ignored", pm, pn, last[13:11]);
            end
        end

        // R7 both open
        shift_word(14'h3A11);
        par_m_i = 9'h0C3; par_n_i = 2'h2;
        ser_load_i = 1'b1;
        par_load_i = 1'b0;
        idle(8);
        chk("R7 parallel wins M N, serial T", 9'h0C3, 2'h2, 3'h7);
        par_load_i = 1'b1;
        idle(8);
        chk("R7 serial resumes after parallel close", 9'h011, 2'h1, 3'h7);
        ser_load_i = 1'b0;
        idle(8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule